// File: doc/BRIEF.md
# Modulus Down-Counter with Sticky Underflow Flag

This block is a down-counter that runs off an external prescaler. Each time a single-cycle `tick` pulse arrives and the run bit is set, the count drops by one. When the count reaches zero, a sticky underflow flag is set. In reload mode, the next tick copies a stored modulus value back into the counter, so one period lasts modulus+1 ticks. In one-shot mode, the counter stays at zero until software loads it again.

Software uses a small register bus with four word addresses. Reads are combinational and show current state in the same cycle. Writes take effect at the clock edge.

The underflow flag can be cleared in two ways:
- Write a one to bit 7 of the status word.
- Turn on the quick-clear control bit. Any read or write of the count word then clears the flag as a side effect.

The interrupt output is the flag gated by an enable bit. The bus has no data stream, so there is no valid/ready handshake and no back-pressure. Every access completes in the cycle it is presented.

Top module: `modcount_timer`

## Requirements
- R1: After reset, the control, modulus, count and status words all read 0, and `irq` is 0.
- R2: The count decrements by one on a clock edge only when `tick` is 1, run (control bit 3) is 1, and the count is non-zero. With `tick` low or run clear, the count holds.
- R3: A tick that moves the count to zero, or a reload of a zero modulus, sets the underflow flag. The flag reads as bit 7 of the status word (address 3) on the edge where the count becomes zero.
- R4: In reload mode (control bit 0 = 1), a tick at count zero loads the modulus value (address 1). Flags then recur every modulus+1 ticks.
- R5: In one-shot mode (control bit 0 = 0), the count holds at zero. Further ticks set no new flag.
- R6: Writing the status word with bit 7 = 1 clears the flag. Writing it with bit 7 = 0 leaves the flag unchanged.
- R7: With quick-clear (control bit 1) set, any read or write of the count word (address 2) clears the flag. With quick-clear off, reading the count leaves the flag unchanged.
- R8: When a set event and a clear request fall in the same cycle, the flag ends up set.
- R9: A modulus write while the counter is stopped (run clear, or one-shot mode at zero) also loads the count. While the counter is running, a modulus write leaves the count unchanged.
- R10: A write to the count word loads the count directly. A bus load takes priority over a tick in the same cycle.
- R11: `irq` is 1 exactly when the flag is set and interrupt enable (control bit 2) is 1.
- R12: The address map is: 0 = control (bits 3:0), 1 = modulus, 2 = count, 3 = status. Read data shows the addressed word in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Single-cycle prescaler pulse |
| bus_addr | input | 2 | Word address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (a read of the count word matters for quick-clear) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from `bus_addr` |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle, the bound checker checks these properties:
- single-step decrement
- hold at zero in one-shot mode
- reload from the modulus
- flag set on reaching zero
- set-over-clear priority
- flag stickiness and write-one-clear
- irq implying the flag

Some behaviour can only be shown by the bench's scenarios:
- the full reload period for each swept modulus value
- immediate loading of the modulus when stopped, versus no effect when running
- that quick-clear does nothing when its bit is off
- readback of the address map

// File: rtl/mdc_pkg.sv
package mdc_pkg;

  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_MOD  = 2'd1,
    ADDR_CNT  = 2'd2,
    ADDR_STAT = 2'd3
  } reg_addr_e;

  localparam int CTRL_W        = 4;
  localparam int STAT_FLAG_BIT = 7;

  // bit order matches control word: {run, irq_en, qclr, reload}
  typedef struct packed {
    logic run;
    logic irq_en;
    logic qclr;
    logic reload;
  } ctrl_t;

endpackage

// File: rtl/mdc_regs.sv
module mdc_regs
  import mdc_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [CW-1:0] bus_wdata,
  output ctrl_t         ctrl,
  output logic [CW-1:0] modulus,
  output logic          cnt_wr,
  output logic          mod_wr,
  output logic          stat_w1c,
  output logic          cnt_access
);

  reg_addr_e addr;
  logic      ctrl_wr;

  assign addr       = reg_addr_e'(bus_addr);
  assign ctrl_wr    = bus_wr && (addr == ADDR_CTRL);
  assign mod_wr     = bus_wr && (addr == ADDR_MOD);
  assign cnt_wr     = bus_wr && (addr == ADDR_CNT);
  assign stat_w1c   = bus_wr && (addr == ADDR_STAT) && bus_wdata[STAT_FLAG_BIT];
  assign cnt_access = (bus_wr || bus_rd) && (addr == ADDR_CNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl    <= '0;
      modulus <= '0;
    end else begin
      if (ctrl_wr) ctrl    <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
      if (mod_wr)  modulus <= bus_wdata;
    end
  end

endmodule

// File: rtl/mdc_core.sv
module mdc_core #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          run,
  input  logic          reload,
  input  logic [CW-1:0] modulus,
  input  logic          cnt_wr,
  input  logic          mod_wr,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] count,
  output logic          hit
);

  localparam logic [CW-1:0] ZERO = '0;
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic          at_zero;
  logic          stopped;
  logic          bus_load;
  logic          step;
  logic [CW-1:0] count_nx;

  assign at_zero  = (count == ZERO);
  assign stopped  = !run || (!reload && at_zero);
  assign bus_load = cnt_wr || (mod_wr && stopped);
  assign step     = tick && run && !bus_load && !(at_zero && !reload);

  always_comb begin
    count_nx = count;
    hit      = 1'b0;
    if (cnt_wr) begin
      count_nx = wdata;
    end else if (mod_wr && stopped) begin
      count_nx = wdata;
    end else if (step) begin
      count_nx = at_zero ? modulus : (count - ONE);
      hit      = (count_nx == ZERO);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count_nx;
  end

endmodule

// File: rtl/mdc_flag.sv
module mdc_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic w1c,
  input  logic quick_clr,
  output logic flag
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                flag <= 1'b0;
    else if (set_evt)          flag <= 1'b1;
    else if (w1c || quick_clr) flag <= 1'b0;
  end

endmodule

// File: rtl/modcount_timer.sv
module modcount_timer
  import mdc_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [1:0]    bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [CW-1:0] bus_wdata,
  output logic [CW-1:0] bus_rdata,
  output logic          irq
);

  ctrl_t         ctrl;
  logic [CW-1:0] modulus;
  logic [CW-1:0] count;
  logic          cnt_wr, mod_wr, stat_w1c, cnt_access;
  logic          hit, flag;

  mdc_regs #(.CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .ctrl(ctrl), .modulus(modulus),
    .cnt_wr(cnt_wr), .mod_wr(mod_wr), .stat_w1c(stat_w1c),
    .cnt_access(cnt_access)
  );

  mdc_core #(.CW(CW)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(ctrl.run),
    .reload(ctrl.reload), .modulus(modulus), .cnt_wr(cnt_wr),
    .mod_wr(mod_wr), .wdata(bus_wdata), .count(count), .hit(hit)
  );

  mdc_flag u_flag (
    .clk(clk), .rst_n(rst_n), .set_evt(hit), .w1c(stat_w1c),
    .quick_clr(ctrl.qclr && cnt_access), .flag(flag)
  );

  assign irq = flag && ctrl.irq_en;

  always_comb begin
    bus_rdata = '0;
    unique case (reg_addr_e'(bus_addr))
      ADDR_CTRL: bus_rdata[CTRL_W-1:0] = ctrl;
      ADDR_MOD:  bus_rdata = modulus;
      ADDR_CNT:  bus_rdata = count;
      ADDR_STAT: bus_rdata[STAT_FLAG_BIT] = flag;
      default:   bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/modcount_checks.sv
module modcount_checks #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic [1:0]    bus_addr,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic [CW-1:0] bus_wdata,
  input logic          irq,
  input logic [CW-1:0] count,
  input logic [CW-1:0] modulus,
  input logic          flag,
  input logic          run,
  input logic          reload,
  input logic          qclr
);

  logic load_any, live_tick, set_now, clr_req;

  assign load_any  = bus_wr && (bus_addr == 2'd1 || bus_addr == 2'd2);
  assign live_tick = tick && run && !load_any;
  assign set_now   = live_tick && ((count == CW'(1)) ||
                     (count == '0 && reload && modulus == '0));
  assign clr_req   = (bus_wr && bus_addr == 2'd3 && bus_wdata[7]) ||
                     (qclr && (bus_wr || bus_rd) && bus_addr == 2'd2);

  assert_decrement_R2: assert property (@(posedge clk) disable iff (!rst_n)
    live_tick && count != '0 |=> count == $past(count) - CW'(1));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !load_any |=> $stable(count));

  assert_flag_on_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    set_now |=> flag && count == '0);

  assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    live_tick && reload && count == '0 |=> count == $past(modulus));

  assert_oneshot_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !reload && count == '0 && !load_any |=> count == '0);

  assert_w1c_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req && !set_now |=> !flag);

  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !clr_req |=> flag);

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    set_now && clr_req |=> flag);

  assert_irq_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag);

endmodule

bind modcount_timer modcount_checks #(.CW(CW)) u_checks (
  .clk(clk), .rst_n(rst_n), .tick(tick), .bus_addr(bus_addr),
  .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .irq(irq),
  .count(count), .modulus(modulus), .flag(flag), .run(ctrl.run),
  .reload(ctrl.reload), .qclr(ctrl.qclr)
);

// File: tb/modcount_timer_test.sv
module modcount_timer_test;

  localparam int CW = 16;
  localparam logic [15:0] C_RELOAD = 16'h1, C_QCLR = 16'h2,
                          C_IRQ = 16'h4, C_RUN = 16'h8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic [1:0]    bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [CW-1:0] bus_wdata = '0;
  logic [CW-1:0] bus_rdata;
  logic          irq;

  int n_checks = 0;
  int n_fail   = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  modcount_timer #(.CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic expect_reg(input string req, input logic [1:0] a, input logic [15:0] e);
    logic [15:0] v;
    rd(a, v);
    check(req, 32'(v), 32'(e));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 4; a++) expect_reg("R1", 2'(a), 16'h0);
    check("R1 irq", 32'(irq), 0);

    // R2 no run: ticks have no effect
    wr(2, 16'd5);
    pulse(3);
    expect_reg("R2 no run", 2, 16'd5);

    // R12 control readback
    wr(0, 16'hF);
    expect_reg("R12 ctrl", 0, 16'hF);
    wr(0, 16'h0);

    // R9 modulus write when stopped loads count
    wr(1, 16'd11);
    expect_reg("R9 stopped load", 2, 16'd11);
    expect_reg("R12 modulus", 1, 16'd11);

    // R2/R3/R5 one-shot sweep
    wr(0, C_RUN);
    for (int L = 1; L <= 6; L++) begin
      wr(2, 16'd0);
      wr(1, 16'(L));
      wr(3, 16'h80);
      expect_reg("R9 one-shot load", 2, 16'(L));
      pulse(L - 1);
      expect_reg("R2 decrement", 2, 16'd1);
      expect_reg("R3 no early flag", 3, 16'h0);
      pulse(1);
      expect_reg("R3 zero", 2, 16'd0);
      expect_reg("R3 flag", 3, 16'h80);
      wr(3, 16'h80);
      pulse(3);
      expect_reg("R5 hold zero", 2, 16'd0);
      expect_reg("R5 no new flag", 3, 16'h0);
    end

    // R4 reload sweep, arithmetic model per tick
    wr(0, C_RUN | C_RELOAD);
    for (int M = 0; M <= 4; M++) begin
      wr(1, 16'(M));
      wr(2, 16'(M));
      wr(3, 16'h80);
      e = M;
      for (int t = 0; t < 3 * (M + 1); t++) begin
        pulse(1);
        e = (e == 0) ? M : e - 1;
        expect_reg("R4 count", 2, 16'(e));
        expect_reg("R4 flag", 3, (e == 0) ? 16'h80 : 16'h0);
        if (e == 0) wr(3, 16'h80);
      end
    end

    // R9 running modulus write leaves count; later reload uses it
    wr(2, 16'd7);
    wr(1, 16'd3);
    expect_reg("R9 running", 2, 16'd7);
    pulse(8);
    expect_reg("R4 new modulus", 2, 16'd3);

    // R10 bus load beats tick
    @(negedge clk);
    bus_addr = 2; bus_wdata = 16'd9; bus_wr = 1'b1; tick = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; tick = 1'b0;
    expect_reg("R10 priority", 2, 16'd9);

    // R6 write of 0 keeps flag, write of 1 clears
    wr(2, 16'd1);
    pulse(1);
    wr(3, 16'h7F);
    expect_reg("R6 zero no effect", 3, 16'h80);
    wr(3, 16'h80);
    expect_reg("R6 clear", 3, 16'h0);

    // R7 quick clear off: count read keeps flag
    wr(2, 16'd1);
    pulse(1);
    rd(2, v);
    expect_reg("R7 off", 3, 16'h80);
    // quick clear on: read clears
    wr(0, C_RUN | C_RELOAD | C_QCLR);
    rd(2, v);
    expect_reg("R7 read clears", 3, 16'h0);
    // quick clear on: write clears
    wr(0, C_RUN | C_RELOAD);
    wr(2, 16'd1);
    pulse(1);
    wr(0, C_RUN | C_RELOAD | C_QCLR);
    wr(2, 16'd4);
    expect_reg("R7 write clears", 3, 16'h0);
    wr(0, C_RUN | C_RELOAD);

    // R8 set wins over same-cycle clear
    wr(2, 16'd1);
    @(negedge clk);
    bus_addr = 3; bus_wdata = 16'h80; bus_wr = 1'b1; tick = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; tick = 1'b0;
    expect_reg("R8 set wins", 3, 16'h80);

    // R11 interrupt gating
    check("R11 masked", 32'(irq), 0);
    wr(0, C_RUN | C_RELOAD | C_IRQ);
    #1 check("R11 raised", 32'(irq), 1);
    wr(3, 16'h80);
    #1 check("R11 cleared", 32'(irq), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule